// File: doc/BRIEF.md
# Presettable Cascaded Clock Divider

This block divides a fast clock by a programmable integer ratio without any asynchronous clear. A fixed binary prescaler turns the input clock into a strobe that fires once every eight cycles. A chain of 4-bit up-counting slices advances only on that strobe. The slices all run from the same clock. Each slice raises a carry when it holds all ones, and that carry enables the next more significant slice. When the whole chain is full, the next strobe edge synchronously reloads the chain with a start value. The start value is the bitwise complement of (N-1), so a period lasts exactly N strobes.

The block has two outputs. The first is a one-cycle terminal pulse per output period. The second is a divided clock taken from the most significant count bit that toggles within a period. The ratio input may change at any time. It is captured only when the chain reloads, so a period already in progress always finishes with its old length.

Top module: `presettable_divider`

## Requirements
- R1: For a ratio N with 2 <= N <= 4095, `tc_o` is high for exactly one clock cycle, and consecutive pulses are 8*N clock cycles apart.
- R2: A synchronous reset clears the prescaler and loads the start value of the current `n_i`. The first `tc_o` after reset is high in the (8*N-1)-th clock cycle after the first edge with reset low.
- R3: For N >= 2, `div_o` equals count bit k, where k is the index of the most significant set bit of N-1. `div_o` is low right after each reload and high for the last 8*2^k cycles of each period, including the `tc_o` cycle.
- R4: A ratio of 0 or 1 means divide-by-one on the strobe. `tc_o` pulses every 8 cycles, and `div_o` equals `tc_o`.
- R5: A new `n_i` takes effect only at a reload. A period in progress finishes with the ratio it started with.
- R6: While reset is applied, and on the cycle after a reset edge, `tc_o` is low. For N >= 2, `div_o` is also low.
- R7: The count changes only on an edge where the prescaler strobe was high. For N >= 2, `div_o` therefore changes only on the first cycle of an 8-cycle strobe window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the whole block |
| rst_i | input | 1 | Synchronous active-high reset |
| n_i | input | 12 | Division ratio N for the long divider (0 and 1 mean one) |
| tc_o | output | 1 | One-cycle terminal pulse, once per output period |
| div_o | output | 1 | Divided clock taken from a count bit |

## Verification
Every output is decoded from registers, so a change in the count appears on the cycle just after the clock edge on which the strobe was high. The bench samples on the falling edge and counts cycles relative to a `tc_o` sample. A reload shows on the sample right after `tc_o`, and each count value then holds for eight samples. The first pulse after reset is due 8*N-1 samples after release. A ratio written in the middle of a period is expected to show only in the period that starts after the next reload, so the partial period is checked against the old ratio.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // default geometry of the divider
    localparam int CDIV_SLICE_W = 4;
    localparam int CDIV_SLICES  = 3;
    localparam int CDIV_PRE_W   = 3;

    // how the divided output is produced
    typedef enum logic {
        MODE_BYPASS = 1'b0,   // ratio 0/1: output follows the strobe
        MODE_TAP    = 1'b1    // output is a count bit
    } cdiv_mode_e;

    // index width able to address every count bit (at least one bit)
    function automatic int cdiv_idx_w(input int bits);
        int w;
        w = 1;
        while ((1 << w) < bits) w++;
        return w;
    endfunction

endpackage

// File: rtl/cdiv_prescaler.sv
module cdiv_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic en_o
);
    generate
        if (PRE_W == 0) begin : g_none
            assign en_o = 1'b1;
        end else begin : g_cnt
            logic [PRE_W-1:0] cnt_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) cnt_q <= '0;
                else       cnt_q <= cnt_q + 1'b1;
            end
            // strobe while the counter is full
            assign en_o = &cnt_q;
        end
    endgenerate
endmodule

// File: rtl/cdiv_slice.sv
module cdiv_slice #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         load_i,
    input  logic [W-1:0] preset_i,
    input  logic         en_i,
    output logic [W-1:0] q_o,
    output logic         carry_o
);
    logic [W-1:0] q_q;

    always_ff @(posedge clk_i) begin
        if (load_i)    q_q <= preset_i;
        else if (en_i) q_q <= q_q + 1'b1;
    end

    assign q_o     = q_q;
    // carry to the next slice: this slice is full and enabled
    assign carry_o = en_i & (&q_q);
endmodule

// File: rtl/cdiv_ratio_ctrl.sv
module cdiv_ratio_ctrl
    import cdiv_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TAP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tc_i,
    input  logic [CNT_W-1:0] n_i,
    output logic [CNT_W-1:0] preset_o,
    output logic [CNT_W-1:0] n_act_o,
    output logic [TAP_W-1:0] tap_o,
    output cdiv_mode_e       mode_o
);
    logic [CNT_W-1:0] n_act_q;
    logic [CNT_W-1:0] nm1_in;
    logic [CNT_W-1:0] nm1_act;
    logic [TAP_W-1:0] tap;

    // ratio captured only when the chain restarts
    always_ff @(posedge clk_i) begin
        if (rst_i || tc_i) n_act_q <= n_i;
    end

    // start value for the next period, derived from the incoming ratio
    always_comb begin
        nm1_in = n_i - CNT_W'(1);
        if (n_i <= CNT_W'(1)) preset_o = '1;
        else                  preset_o = ~nm1_in;
    end

    // output tap: highest set bit of (active ratio - 1)
    always_comb begin
        nm1_act = n_act_q - CNT_W'(1);
        tap     = '0;
        for (int b = 0; b < CNT_W; b++) begin
            if (nm1_act[b]) tap = TAP_W'(b);
        end
    end

    assign tap_o   = tap;
    assign n_act_o = n_act_q;
    assign mode_o  = (n_act_q <= CNT_W'(1)) ? MODE_BYPASS : MODE_TAP;
endmodule

// File: rtl/presettable_divider.sv
module presettable_divider
    import cdiv_pkg::*;
#(
    parameter int SLICE_W = CDIV_SLICE_W,
    parameter int SLICES  = CDIV_SLICES,
    parameter int PRE_W   = CDIV_PRE_W,
    parameter int CNT_W   = SLICE_W * SLICES
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] n_i,
    output logic             tc_o,
    output logic             div_o
);
    localparam int TAP_W = cdiv_idx_w(CNT_W);

    logic              pre_en;
    logic [SLICES:0]   en_chain;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  preset;
    logic [CNT_W-1:0]  n_act;
    logic [TAP_W-1:0]  tap;
    cdiv_mode_e        mode;
    logic              tc;
    logic              load;

    cdiv_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_o  (pre_en)
    );

    assign en_chain[0] = pre_en;
    assign tc          = en_chain[SLICES];
    assign load        = rst_i | tc;

    generate
        for (genvar s = 0; s < SLICES; s++) begin : g_slice
            cdiv_slice #(.W(SLICE_W)) slice_i (
                .clk_i    (clk_i),
                .load_i   (load),
                .preset_i (preset[s*SLICE_W +: SLICE_W]),
                .en_i     (en_chain[s]),
                .q_o      (count[s*SLICE_W +: SLICE_W]),
                .carry_o  (en_chain[s+1])
            );
        end
    endgenerate

    cdiv_ratio_ctrl #(.CNT_W(CNT_W), .TAP_W(TAP_W)) ctrl_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tc_i     (tc),
        .n_i      (n_i),
        .preset_o (preset),
        .n_act_o  (n_act),
        .tap_o    (tap),
        .mode_o   (mode)
    );

    assign tc_o  = tc;
    assign div_o = (mode == MODE_BYPASS) ? tc : count[tap];
endmodule

// File: rtl/presettable_divider_chk.sv
module presettable_divider_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [CNT_W-1:0] n_i,
    input logic             tc_o,
    input logic             div_o,
    input logic             pre_en,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] n_act
);
    // R1
    tc_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_o |=> !tc_o);

    // R7
    count_hold_chk: assert property (@(posedge clk_i)
        (!pre_en && !rst_i) |=> $stable(count));

    // R5
    ratio_hold_chk: assert property (@(posedge clk_i)
        (!tc_o && !rst_i) |=> $stable(n_act));

    // R3
    tap_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tc_o && n_act >= CNT_W'(2)) |-> div_o);

    // R3
    tap_low_chk: assert property (@(posedge clk_i)
        (tc_o && !rst_i && n_i >= CNT_W'(2)) |=> !div_o);

    // R4
    bypass_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (n_act <= CNT_W'(1) && !pre_en) |-> !div_o);

    // R6
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |=> !tc_o);
endmodule

bind presettable_divider presettable_divider_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .n_i    (n_i),
    .tc_o   (tc_o),
    .div_o  (div_o),
    .pre_en (pre_en),
    .count  (count),
    .n_act  (n_act)
);

// File: tb/presettable_divider_tb_top.sv
`timescale 1ns/1ps
module presettable_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] n   = 12'd3;
    logic        tc;
    logic        div;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    presettable_divider dut_i (
        .clk_i (clk),
        .rst_i (rst),
        .n_i   (n),
        .tc_o  (tc),
        .div_o (div)
    );

    // {ratio[63:48], period[47:24], high cycles[23:0]}
    localparam int NV = 10;
    localparam logic [63:0] VEC [NV] = '{
        {16'd3,    24'd24,    24'd16},
        {16'd2,    24'd16,    24'd8},
        {16'd5,    24'd40,    24'd32},
        {16'd16,   24'd128,   24'd64},
        {16'd17,   24'd136,   24'd128},
        {16'd100,  24'd800,   24'd512},
        {16'd0,    24'd8,     24'd1},
        {16'd1,    24'd8,     24'd1},
        {16'd2048, 24'd16384, 24'd8192},
        {16'd2590, 24'd20720, 24'd16384}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
            summary();
            $finish;
        end
    end

    // count samples until tc_o is seen (returns count)
    task automatic wait_tc(output int cnt);
        cnt = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            cnt++;
            if (tc) break;
        end
    endtask

    // called on a tc_o sample; measures the following period
    task automatic measure(output int period, output int highs, output int bad);
        logic prev;
        prev   = div;
        period = 0;
        highs  = 0;
        bad    = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            period++;
            if (div) highs++;
            if (div != prev && (period % 8) != 1) bad++;
            prev = div;
            if (tc) break;
        end
    endtask

    initial begin
        int cnt, per, hi, bad, nv;

        // reset state (R6)
        repeat (3) @(negedge clk);
        check(tc == 1'b0, "R6 tc in reset", int'(tc), 0);
        check(div == 1'b0, "R6 div in reset", int'(div), 0);
        rst = 1'b0;

        // first pulse after reset, N=3 (R2)
        wait_tc(cnt);
        check(cnt == 23, "R2 first tc after reset", cnt, 23);

        // table walk (R1, R3, R4, R7)
        for (int v = 0; v < NV; v++) begin
            nv = int'(VEC[v][63:48]);
            n  = VEC[v][59:48];
            wait_tc(cnt);
            measure(per, hi, bad);
            check(per == int'(VEC[v][47:24]),
                  (nv <= 1) ? "R4 period" : "R1 period", per, int'(VEC[v][47:24]));
            check(hi == int'(VEC[v][23:0]),
                  (nv <= 1) ? "R4 div high" : "R3 div high", hi, int'(VEC[v][23:0]));
            if (nv >= 2) check(bad == 0, "R7 div edge alignment", bad, 0);
        end

        // ratio change in mid-period (R5)
        n = 12'd100;
        wait_tc(cnt);
        cnt = 0;
        repeat (50) begin
            @(negedge clk);
            cnt++;
        end
        n = 12'd5;
        wait_tc(per);
        cnt = cnt + per;
        check(cnt == 800, "R5 old ratio completes", cnt, 800);
        measure(per, hi, bad);
        check(per == 40, "R5 new ratio period", per, 40);

        // reset in mid-run (R2, R6)
        repeat (13) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(tc == 1'b0, "R6 tc after reset edge", int'(tc), 0);
        check(div == 1'b0, "R6 div after reset edge", int'(div), 0);
        rst = 1'b0;
        wait_tc(cnt);
        check(cnt == 39, "R2 restart after reset", cnt, 39);

        summary();
        $finish;
    end
endmodule